// File: doc/BRIEF.md
# LNB Supply Controller Serial Control Register

This block is a two-wire serial (I2C) slave that holds the single 8-bit control and status register of a satellite LNB supply controller. It sees SCL and SDA as sampled inputs. It pulls SDA low through an open-drain enable, `sda_oe`. Both lines are re-timed into the system clock domain. START and STOP conditions and SCL edges are found there. The slave then responds to one 7-bit address, picked from four by a 2-bit board strap.

Six register bits are control outputs that a bus master can write: power enable, high-voltage select, cable-drop boost, continuous tone, reduced current limit and static clamp mode. The two top bits are diagnostic flags that come from the protection circuits: overload and overheat. The master can read these flags but cannot write them. A read returns the whole register and repeats it for as long as the master acknowledges.

A supply-good input stands in for the undervoltage monitor. While it is low, the register is forced to zero and the slave ignores the bus. There is no data stream at the block edge, so it has no valid/ready handshake. Every pin is plain control or status, and the serial bus is the only way in for data.

Top module: `lnbi2c_regs`

## Requirements
- R1: After reset, `sda_oe` is 0 and `ctrl_out` is 0.
- R2: The slave address is 7'b00010 followed by `addr_strap[1:0]` (0x08 + strap). The R/W bit is the LSB of the address byte, with 0 meaning write, so the write address byte is 0x10 + 2*strap. On a match the slave holds SDA low through the whole ninth clock.
- R3: On an address mismatch the slave gives no acknowledge. It ignores every byte up to the next START, and `ctrl_out` does not change.
- R4: In a write, bits 5:0 of the first data byte following the address go to `ctrl_out`. The bit map is: bit0 power enable, bit1 high-voltage select, bit2 cable boost, bit3 tone on, bit4 low current limit, bit5 static clamp. Each byte is sent MSB first and each received data byte is acknowledged.
- R5: Bits 7:6 of a written byte are ignored. Any data byte after the first in a write transaction is acknowledged and then discarded.
- R6: In a read, the slave sends {overheat, overload, ctrl_out[5:0]} MSB first. The value is sampled at the start of each byte. A master acknowledge brings a fresh copy. A master no-acknowledge ends the read, and SDA is released from then on.
- R7: While `supply_ok` is 0, `ctrl_out` is held at 0 and the slave neither acknowledges nor drives SDA. Once supply returns, the register stays 0 until it is written.
- R8: A START or STOP in the middle of a byte returns the slave to address reception or to idle, without changing the register. A repeated START begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Sampled serial clock line |
| sda_in | input | 1 | Sampled serial data line (wired level) |
| sda_oe | output | 1 | 1 pulls SDA low |
| addr_strap | input | 2 | Selects one of four slave addresses |
| supply_ok | input | 1 | Supply-good; 0 clears the register and silences the slave |
| fault_overload | input | 1 | Overload flag, read as bit 6 |
| fault_overheat | input | 1 | Overheat flag, read as bit 7 |
| ctrl_out | output | 6 | Writable control bits |

## Verification
The bench writes 0xFF and checks that only bits 5:0 land. A design that stored the flag positions would show bits 7:6. It sends a second data byte in the same write and checks that the first value survives. Double-writing would overwrite it. It also changes a fault input between two read bytes and expects the second copy to show the change, which catches a read value latched only once per transaction. It addresses the slave under a stale strap, aborts an address byte with STOP, and breaks a data byte with a repeated START. A slave that acknowledged a foreign address, resumed a half byte, or committed a partial byte would then change the register or miss the next access. Finally it drops supply mid-operation and expects the register cleared, no acknowledge, and recovery only after a fresh write.

// File: rtl/lnbi2c_pkg.sv
package lnbi2c_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);
  localparam int LN_SCL = 0;
  localparam int LN_SDA = 1;
  localparam int LINES  = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK
  } bus_st_t;
endpackage

// File: rtl/lnbi2c_sync.sv
module lnbi2c_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] cur,
  output logic [LINES-1:0] prev
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], raw[i]};
    end
    assign cur[i] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '1;
    else        prev <= cur;
  end
endmodule

// File: rtl/lnbi2c_events.sv
module lnbi2c_events
  import lnbi2c_pkg::*;
(
  input  logic [LINES-1:0] cur,
  input  logic [LINES-1:0] prev,
  output logic             scl_rise,
  output logic             scl_fall,
  output logic             ev_start,
  output logic             ev_stop
);
  logic scl_hold;
  always_comb begin
    scl_hold = cur[LN_SCL] & prev[LN_SCL];
    scl_rise = cur[LN_SCL] & ~prev[LN_SCL];
    scl_fall = ~cur[LN_SCL] & prev[LN_SCL];
    ev_start = scl_hold & prev[LN_SDA] & ~cur[LN_SDA];
    ev_stop  = scl_hold & ~prev[LN_SDA] & cur[LN_SDA];
  end
endmodule

// File: rtl/lnbi2c_fsm.sv
module lnbi2c_fsm
  import lnbi2c_pkg::*;
#(
  parameter int CTRL_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_ok,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic [6:0]        own_addr,
  input  logic [BYTE_W-1:0] rd_val,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [CTRL_W-1:0] wr_data
);
  bus_st_t           st;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] tx;
  logic [CNT_W-1:0]  cnt;
  logic              done;
  logic              rw;
  logic              first;
  logic              mack;

  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  assign wr_data = shreg[CTRL_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; shreg <= '0; tx <= '0; cnt <= '0;
      done <= 1'b0; rw <= 1'b0; first <= 1'b0; mack <= 1'b0;
      sda_oe <= 1'b0; wr_en <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (!supply_ok) begin
        st <= ST_IDLE; sda_oe <= 1'b0; done <= 1'b0; cnt <= '0;
      end else if (ev_start) begin
        st <= ST_ADDR; sda_oe <= 1'b0; done <= 1'b0; cnt <= '0;
      end else if (ev_stop) begin
        st <= ST_IDLE; sda_oe <= 1'b0; done <= 1'b0; cnt <= '0;
      end else begin
        case (st)
          ST_ADDR, ST_WDATA: begin
            if (scl_rise) begin
              shreg <= {shreg[BYTE_W-2:0], sda_s};
              cnt   <= cnt + 1'b1;
              if (cnt == LAST) done <= 1'b1;
            end else if (scl_fall && done) begin
              done <= 1'b0;
              if (st == ST_ADDR) begin
                if (shreg[BYTE_W-1:1] == own_addr) begin
                  sda_oe <= 1'b1;
                  rw     <= shreg[0];
                  st     <= ST_AACK;
                end else begin
                  st <= ST_IDLE;
                end
              end else begin
                sda_oe <= 1'b1;
                st     <= ST_WACK;
                wr_en  <= first;
                first  <= 1'b0;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              first <= 1'b1;
              cnt   <= '0;
              if (rw) begin
                tx     <= rd_val;
                sda_oe <= ~rd_val[BYTE_W-1];
                st     <= ST_RDATA;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_WDATA;
              end
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              st     <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
              if (cnt == LAST) done <= 1'b1;
            end else if (scl_fall) begin
              if (done) begin
                done   <= 1'b0;
                sda_oe <= 1'b0;
                st     <= ST_RACK;
              end else begin
                tx     <= {tx[BYTE_W-2:0], 1'b0};
                sda_oe <= ~tx[BYTE_W-2];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              cnt <= '0;
              if (mack) begin
                tx     <= rd_val;
                sda_oe <= ~rd_val[BYTE_W-1];
                st     <= ST_RDATA;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: begin
            sda_oe <= 1'b0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/lnbi2c_regfile.sv
module lnbi2c_regfile #(
  parameter int CTRL_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_ok,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              fault_overload,
  input  logic              fault_overheat,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [CTRL_W+1:0] rd_val
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ctrl_q <= '0;
    else if (!supply_ok) ctrl_q <= '0;
    else if (wr_en)      ctrl_q <= wr_data;
  end

  assign rd_val = {fault_overheat, fault_overload, ctrl_q};
endmodule

// File: rtl/lnbi2c_regs.sv
module lnbi2c_regs
  import lnbi2c_pkg::*;
#(
  parameter logic [6:0] ADDR_BASE   = 7'h08,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_oe,
  input  logic [1:0] addr_strap,
  input  logic       supply_ok,
  input  logic       fault_overload,
  input  logic       fault_overheat,
  output logic [5:0] ctrl_out
);
  localparam int CTRL_W = BYTE_W - 2;

  logic [LINES-1:0] cur, prev;
  logic             scl_rise, scl_fall, ev_start, ev_stop;
  logic             scl_s, sda_s;
  logic             wr_en;
  logic [CTRL_W-1:0] wr_data;
  logic [BYTE_W-1:0] rd_val;
  logic [6:0]        own_addr;

  assign own_addr = ADDR_BASE | 7'(addr_strap);
  assign scl_s    = cur[LN_SCL];
  assign sda_s    = cur[LN_SDA];

  lnbi2c_sync #(.STAGES(SYNC_STAGES), .LINES(LINES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .raw({sda_in, scl_in}), .cur(cur), .prev(prev)
  );

  lnbi2c_events u_evt (
    .cur(cur), .prev(prev),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .ev_start(ev_start), .ev_stop(ev_stop)
  );

  lnbi2c_fsm #(.CTRL_W(CTRL_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .ev_start(ev_start), .ev_stop(ev_stop),
    .own_addr(own_addr), .rd_val(rd_val),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_data(wr_data)
  );

  lnbi2c_regfile #(.CTRL_W(CTRL_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
    .wr_en(wr_en), .wr_data(wr_data),
    .fault_overload(fault_overload), .fault_overheat(fault_overheat),
    .ctrl_q(ctrl_out), .rd_val(rd_val)
  );
endmodule

// File: rtl/lnbi2c_regs_chk.sv
module lnbi2c_regs_chk #(
  parameter int CTRL_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              supply_ok,
  input logic              sda_oe,
  input logic [CTRL_W-1:0] ctrl_out,
  input logic              wr_pulse,
  input logic              scl_sync,
  input logic              start_evt
);
  assert_supply_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> ctrl_out == '0);

  assert_supply_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !sda_oe);

  assert_ctrl_change_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_out) |-> ($past(wr_pulse) || !$past(supply_ok)));

  assert_oe_rise_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_sync);

  assert_start_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_oe);
endmodule

bind lnbi2c_regs lnbi2c_regs_chk #(.CTRL_W(CTRL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .sda_oe(sda_oe),
  .ctrl_out(ctrl_out), .wr_pulse(wr_en), .scl_sync(scl_s),
  .start_evt(ev_start)
);

// File: tb/sim_lnbi2c_regs.sv
`timescale 1ns/1ps
module sim_lnbi2c_regs;
  localparam int H = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [1:0] strap = 2'd0;
  logic       sup = 1'b1;
  logic       f_ol = 1'b0;
  logic       f_ot = 1'b0;
  logic       sda_oe;
  logic [5:0] ctrl;
  logic       line;
  int         n_chk = 0;
  int         n_bad = 0;

  assign line = sda_m & ~sda_oe;

  always #10 clk = ~clk;

  lnbi2c_regs u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(line),
    .sda_oe(sda_oe), .addr_strap(strap), .supply_ok(sup),
    .fault_overload(f_ol), .fault_overheat(f_ot), .ctrl_out(ctrl)
  );

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(H);
    scl_m = 1'b1; wt(H);
    sda_m = 1'b0; wt(H);
    scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    scl_m = 1'b0; sda_m = 1'b0; wt(H);
    scl_m = 1'b1; wt(H);
    sda_m = 1'b1; wt(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wt(H);
      scl_m = 1'b1; wt(H);
      scl_m = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1'b1; wt(H);
    scl_m = 1'b1; wt(H/2);
    ack = ~line;
    wt(H/2);
    scl_m = 1'b0;
  endtask

  task automatic read_byte(input bit give_ack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(H);
      scl_m = 1'b1; wt(H/2);
      d[i] = line;
      wt(H/2);
      scl_m = 1'b0;
    end
    sda_m = give_ack ? 1'b0 : 1'b1; wt(H);
    scl_m = 1'b1; wt(H);
    scl_m = 1'b0;
    sda_m = 1'b1;
  endtask

  task automatic t_reset();
    check(sda_oe == 1'b0, "R1 sda_oe after reset", {7'd0, sda_oe}, 8'h00);
    check(ctrl == 6'd0, "R1 ctrl after reset", {2'b0, ctrl}, 8'h00);
  endtask

  task automatic t_write_basic();
    bit a;
    bus_start();
    send_byte(8'h10, a);
    check(a, "R2 address ack strap0", {7'd0, a}, 8'h01);
    send_byte(8'h2A, a);
    check(a, "R4 data ack", {7'd0, a}, 8'h01);
    bus_stop();
    check(ctrl == 6'h2A, "R4 ctrl after write", {2'b0, ctrl}, 8'h2A);
  endtask

  task automatic t_write_ro();
    bit a;
    bus_start();
    send_byte(8'h10, a);
    send_byte(8'hFF, a);
    wt(4);
    check(ctrl == 6'h3F, "R5 flag bits ignored", {2'b0, ctrl}, 8'h3F);
    send_byte(8'h00, a);
    check(a, "R5 extra byte ack", {7'd0, a}, 8'h01);
    bus_stop();
    check(ctrl == 6'h3F, "R5 extra byte discarded", {2'b0, ctrl}, 8'h3F);
  endtask

  task automatic t_read();
    bit a;
    logic [7:0] d;
    f_ol = 1'b1; f_ot = 1'b0;
    bus_start();
    send_byte(8'h11, a);
    check(a, "R6 read address ack", {7'd0, a}, 8'h01);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(H); scl_m = 1'b1; wt(H/2); d[i] = line; wt(H/2); scl_m = 1'b0;
    end
    check(d == 8'h7F, "R6 first read byte", d, 8'h7F);
    f_ot = 1'b1;
    sda_m = 1'b0; wt(H); scl_m = 1'b1; wt(H); scl_m = 1'b0; sda_m = 1'b1;
    read_byte(1'b0, d);
    check(d == 8'hFF, "R6 repeated byte after master ack", d, 8'hFF);
    wt(H);
    scl_m = 1'b1; wt(H/2);
    check(line == 1'b1, "R6 released after nack", {7'd0, line}, 8'h01);
    wt(H/2); scl_m = 1'b0;
    bus_stop();
  endtask

  task automatic t_strap();
    bit a;
    strap = 2'd2;
    bus_start();
    send_byte(8'h10, a);
    check(!a, "R3 stale address not acked", {7'd0, a}, 8'h00);
    send_byte(8'h00, a);
    check(!a, "R3 data after mismatch not acked", {7'd0, a}, 8'h00);
    bus_stop();
    check(ctrl == 6'h3F, "R3 ctrl unchanged", {2'b0, ctrl}, 8'h3F);
    bus_start();
    send_byte(8'h14, a);
    check(a, "R2 strap2 address ack", {7'd0, a}, 8'h01);
    send_byte(8'h05, a);
    bus_stop();
    check(ctrl == 6'h05, "R2 write via strap2", {2'b0, ctrl}, 8'h05);
  endtask

  task automatic t_abort();
    bit a;
    logic [7:0] d;
    bus_start();
    send_bits(8'h14, 4);
    bus_stop();
    check(sda_oe == 1'b0, "R8 stop mid address idle", {7'd0, sda_oe}, 8'h00);
    bus_start();
    send_byte(8'h14, a);
    check(a, "R8 address after abort", {7'd0, a}, 8'h01);
    send_bits(8'h3F, 3);
    bus_start();
    send_byte(8'h15, a);
    check(a, "R8 repeated start readdress", {7'd0, a}, 8'h01);
    read_byte(1'b0, d);
    check(d == 8'hC5, "R8 partial byte not committed", d, 8'hC5);
    bus_stop();
    check(ctrl == 6'h05, "R8 ctrl unchanged", {2'b0, ctrl}, 8'h05);
  endtask

  task automatic t_supply();
    bit a;
    sup = 1'b0; wt(3);
    check(ctrl == 6'd0, "R7 ctrl cleared on supply low", {2'b0, ctrl}, 8'h00);
    bus_start();
    send_byte(8'h14, a);
    check(!a, "R7 no ack while supply low", {7'd0, a}, 8'h00);
    send_byte(8'h2A, a);
    bus_stop();
    check(ctrl == 6'd0, "R7 ctrl held zero", {2'b0, ctrl}, 8'h00);
    sup = 1'b1; wt(3);
    check(ctrl == 6'd0, "R7 ctrl zero after supply return", {2'b0, ctrl}, 8'h00);
    bus_start();
    send_byte(8'h14, a);
    check(a, "R7 ack after recovery", {7'd0, a}, 8'h01);
    send_byte(8'h12, a);
    bus_stop();
    check(ctrl == 6'h12, "R7 write after recovery", {2'b0, ctrl}, 8'h12);
  endtask

  initial begin
    wt(5);
    rst_n = 1'b1;
    wt(5);
    t_reset();
    t_write_basic();
    t_write_ro();
    t_read();
    t_strap();
    t_abort();
    t_supply();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule